// File: doc/BRIEF.md
# Host/DSP Doorbell Mailbox

This block is a small register file shared by two processors: a host and a DSP. Each side owns a simple 32-bit register port with an address, a write enable, write data and combinational read data. Through it, either side can ring a doorbell toward the other. The command word travelling from host to DSP is called inbound. The command word travelling from DSP to host is called outbound. Each direction also has two message words that carry short operands next to the command. By software convention, opcode 0x1 marks a request and 0x2 marks a response. Two copies of the block form a channel pair, one for requests and one for replies.

Writing a command register ORs the written value into the pending bits. Writing the matching clear register removes exactly the bits that are set in the written value. A doorbell counts as delivered only once the receiver has cleared its bits. The sender learns this by polling the command register until it reads zero. A non-zero outbound command drives the host interrupt, and a non-zero inbound command drives the DSP interrupt. Each interrupt is registered and follows its command register one cycle later.

Each direction has its own doorbell state machine with two states. DB_IDLE means no bits are pending. DB_RING means at least one bit is pending. The transition RING_UP goes from DB_IDLE to DB_RING when the command register becomes non-zero. The transition RING_DOWN goes from DB_RING to DB_IDLE when the command register returns to zero. The interrupt is high exactly while the state is DB_RING.

Top module: `ipc_doorbell_mbox`

## Requirements
- R1: After reset, every register reads zero and both interrupts are low.
- R2: A write to the inbound command (offset 0x00) or the outbound command (offset 0x1C) ORs the written value into that register's pending bits.
- R3: A write to the inbound clear (offset 0x04) or the outbound clear (offset 0x20) clears exactly the bits that are set in the written value and leaves the other bits unchanged.
- R4: When a set and a clear of the same bit land in the same cycle, from either port, the bit ends up clear.
- R5: The host interrupt rises one cycle after the outbound command becomes non-zero and falls one cycle after it returns to zero.
- R6: The DSP interrupt rises one cycle after the inbound command becomes non-zero and falls one cycle after it returns to zero.
- R7: The message words at 0x08, 0x0C (inbound) and 0x24, 0x28 (outbound) store the full written value and can be read from either port. When both ports write the same word in the same cycle, the host value is kept.
- R8: Both clear registers read back as zero. Any offset outside the map reads zero, and a write to it changes no register.
- R9: Writing 0xFFFFFFFF to both clear registers wipes all pending inbound and outbound commands, and both interrupts then drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 8 | Host byte address |
| h_we | input | 1 | Host write enable |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| d_addr | input | 8 | DSP byte address |
| d_we | input | 1 | DSP write enable |
| d_wdata | input | 32 | DSP write data |
| d_rdata | output | 32 | DSP read data (combinational) |
| host_irq | output | 1 | Level interrupt to host, outbound command pending |
| dsp_irq | output | 1 | Level interrupt to DSP, inbound command pending |

## Verification
The command registers are exercised with single-bit and multi-bit opcodes, including bit 31. These patterns show whether a set truly ORs into the register rather than overwriting it, and whether a clear removes only its own bits instead of zeroing the whole word. The bench also drives a set and a clear together, first on different bits and then on the same bit. The first case tells clear-priority apart from simple last-writer-wins, and the second confirms that clear wins on a shared bit. Interrupt timing is sampled on both sides of the registering edge, which separates a registered interrupt from a combinational one. Finally, writes to unmapped offsets and to the clear registers are followed by read-back of the neighbouring registers. This shows that such writes leave no trace in any register.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Base offset of each direction and the offset of each slot inside a direction.
    localparam int IN_BASE  = 'h00;
    localparam int OUT_BASE = 'h1C;
    localparam int CMD_OFS  = 'h00;
    localparam int CLR_OFS  = 'h04;
    localparam int MSG_OFS  = 'h08;
    localparam int WORD_B   = 4;

    // Doorbell state of one direction.
    typedef enum logic {
        DB_IDLE = 1'b0,
        DB_RING = 1'b1
    } db_state_e;

endpackage

// File: rtl/mbox_cmd_chan.sv
module mbox_cmd_chan
    import mbox_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    output logic [DW-1:0] cmd_o,
    output logic          irq_o
);

    logic [DW-1:0] cmd_q;
    db_state_e     state_q;
    db_state_e     state_d;

    // Pending bits: sets are ORed in, and a clear takes priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= (cmd_q | set_i) & ~clr_i;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DB_IDLE;
        else        state_q <= state_d;
    end

    // Next state: RING_UP and RING_DOWN transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_IDLE: if (cmd_q != '0) state_d = DB_RING;
            DB_RING: if (cmd_q == '0) state_d = DB_IDLE;
            default: state_d = DB_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        cmd_o = cmd_q;
        irq_o = (state_q == DB_RING);
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) (clr_i != '0) |=> ((cmd_q & $past(clr_i)) == '0)); // R4
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (set_i != '0) |=> ((cmd_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i))); // R2
    AST_KEEP_UNCLEARED: assert property (@(posedge clk) disable iff (!rst_n) (clr_i != '0) |=> ((cmd_q & $past(cmd_q & ~clr_i)) == $past(cmd_q & ~clr_i))); // R3
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n) $changed(cmd_q != '0) |=> (irq_o == ($past(cmd_q) != '0))); // R5

endmodule

// File: rtl/mbox_msg_bank.sv
module mbox_msg_bank #(
    parameter int DW    = 32,
    parameter int WORDS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORDS-1:0]          h_wen,
    input  logic [WORDS-1:0]          d_wen,
    input  logic [DW-1:0]             h_wdata,
    input  logic [DW-1:0]             d_wdata,
    output logic [WORDS-1:0][DW-1:0]  words_o
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_q;

        // Host write wins over a DSP write to the same word.
        always_ff @(posedge clk) begin
            if (!rst_n)        word_q <= '0;
            else if (h_wen[g]) word_q <= h_wdata;
            else if (d_wen[g]) word_q <= d_wdata;
        end

        assign words_o[g] = word_q;

        AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n) (h_wen[g] && d_wen[g]) |=> (words_o[g] == $past(h_wdata))); // R7
    end

endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int WORDS = 2
) (
    input  logic [AW-1:0]             addr,
    input  logic                      we,
    input  logic [DW-1:0]             wdata,
    input  logic [DW-1:0]             in_cmd,
    input  logic [DW-1:0]             out_cmd,
    input  logic [WORDS-1:0][DW-1:0]  in_msg,
    input  logic [WORDS-1:0][DW-1:0]  out_msg,
    output logic [DW-1:0]             in_set,
    output logic [DW-1:0]             in_clr,
    output logic [DW-1:0]             out_set,
    output logic [DW-1:0]             out_clr,
    output logic [WORDS-1:0]          in_msg_we,
    output logic [WORDS-1:0]          out_msg_we,
    output logic [DW-1:0]             rdata
);

    localparam logic [AW-1:0] A_IN_CMD  = AW'(IN_BASE + CMD_OFS);
    localparam logic [AW-1:0] A_IN_CLR  = AW'(IN_BASE + CLR_OFS);
    localparam logic [AW-1:0] A_OUT_CMD = AW'(OUT_BASE + CMD_OFS);
    localparam logic [AW-1:0] A_OUT_CLR = AW'(OUT_BASE + CLR_OFS);

    // Command set and clear strobes.
    always_comb begin
        in_set  = (we && addr == A_IN_CMD)  ? wdata : '0;
        in_clr  = (we && addr == A_IN_CLR)  ? wdata : '0;
        out_set = (we && addr == A_OUT_CMD) ? wdata : '0;
        out_clr = (we && addr == A_OUT_CLR) ? wdata : '0;
    end

    // Message word strobes.
    for (genvar g = 0; g < WORDS; g++) begin : g_msg
        localparam logic [AW-1:0] A_IN_MSG  = AW'(IN_BASE + MSG_OFS + WORD_B * g);
        localparam logic [AW-1:0] A_OUT_MSG = AW'(OUT_BASE + MSG_OFS + WORD_B * g);
        assign in_msg_we[g]  = we && (addr == A_IN_MSG);
        assign out_msg_we[g] = we && (addr == A_OUT_MSG);
    end

    // Read mux: clear slots and unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (addr == A_IN_CMD)  rdata = in_cmd;
        if (addr == A_OUT_CMD) rdata = out_cmd;
        for (int i = 0; i < WORDS; i++) begin
            if (addr == AW'(IN_BASE + MSG_OFS + WORD_B * i))  rdata = in_msg[i];
            if (addr == AW'(OUT_BASE + MSG_OFS + WORD_B * i)) rdata = out_msg[i];
        end
    end

endmodule

// File: rtl/ipc_doorbell_mbox.sv
module ipc_doorbell_mbox
    import mbox_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int WORDS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_addr,
    input  logic          h_we,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] d_addr,
    input  logic          d_we,
    input  logic [DW-1:0] d_wdata,
    output logic [DW-1:0] d_rdata,
    output logic          host_irq,
    output logic          dsp_irq
);

    localparam logic [AW-1:0] A_IN_CLR  = AW'(IN_BASE + CLR_OFS);
    localparam logic [AW-1:0] A_OUT_CLR = AW'(OUT_BASE + CLR_OFS);

    logic [DW-1:0]            in_cmd, out_cmd;
    logic [WORDS-1:0][DW-1:0] in_msg, out_msg;

    logic [DW-1:0]    h_in_set, h_in_clr, h_out_set, h_out_clr;
    logic [DW-1:0]    d_in_set, d_in_clr, d_out_set, d_out_clr;
    logic [WORDS-1:0] h_in_we, h_out_we, d_in_we, d_out_we;

    mbox_port_dec #(.AW(AW), .DW(DW), .WORDS(WORDS)) i_host_dec (
        .addr       (h_addr),
        .we         (h_we),
        .wdata      (h_wdata),
        .in_cmd     (in_cmd),
        .out_cmd    (out_cmd),
        .in_msg     (in_msg),
        .out_msg    (out_msg),
        .in_set     (h_in_set),
        .in_clr     (h_in_clr),
        .out_set    (h_out_set),
        .out_clr    (h_out_clr),
        .in_msg_we  (h_in_we),
        .out_msg_we (h_out_we),
        .rdata      (h_rdata)
    );

    mbox_port_dec #(.AW(AW), .DW(DW), .WORDS(WORDS)) i_dsp_dec (
        .addr       (d_addr),
        .we         (d_we),
        .wdata      (d_wdata),
        .in_cmd     (in_cmd),
        .out_cmd    (out_cmd),
        .in_msg     (in_msg),
        .out_msg    (out_msg),
        .in_set     (d_in_set),
        .in_clr     (d_in_clr),
        .out_set    (d_out_set),
        .out_clr    (d_out_clr),
        .in_msg_we  (d_in_we),
        .out_msg_we (d_out_we),
        .rdata      (d_rdata)
    );

    // Inbound direction: host rings, DSP is interrupted.
    mbox_cmd_chan #(.DW(DW)) i_in_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (h_in_set | d_in_set),
        .clr_i (h_in_clr | d_in_clr),
        .cmd_o (in_cmd),
        .irq_o (dsp_irq)
    );

    // Outbound direction: DSP rings, host is interrupted.
    mbox_cmd_chan #(.DW(DW)) i_out_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (h_out_set | d_out_set),
        .clr_i (h_out_clr | d_out_clr),
        .cmd_o (out_cmd),
        .irq_o (host_irq)
    );

    mbox_msg_bank #(.DW(DW), .WORDS(WORDS)) i_in_msgs (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_wen   (h_in_we),
        .d_wen   (d_in_we),
        .h_wdata (h_wdata),
        .d_wdata (d_wdata),
        .words_o (in_msg)
    );

    mbox_msg_bank #(.DW(DW), .WORDS(WORDS)) i_out_msgs (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_wen   (h_out_we),
        .d_wen   (d_out_we),
        .h_wdata (h_wdata),
        .d_wdata (d_wdata),
        .words_o (out_msg)
    );

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (h_addr == A_IN_CLR || h_addr == A_OUT_CLR) |-> (h_rdata == '0)); // R8
    AST_IRQ_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) ($past(out_cmd) == '0 && $past(in_cmd) == '0) |-> (!host_irq && !dsp_irq)); // R6
    AST_FULL_WIPE: assert property (@(posedge clk) disable iff (!rst_n) (h_we && h_addr == A_OUT_CLR && h_wdata == '1) |=> (out_cmd == '0)); // R9

endmodule

// File: tb/test_ipc_doorbell_mbox.sv
`timescale 1ns/1ps
module test_ipc_doorbell_mbox;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  h_addr, d_addr;
    logic        h_we, d_we;
    logic [31:0] h_wdata, d_wdata;
    logic [31:0] h_rdata, d_rdata;
    logic        host_irq, dsp_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk; // 125 MHz

    ipc_doorbell_mbox i_ipc_doorbell_mbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_addr   (h_addr),
        .h_we     (h_we),
        .h_wdata  (h_wdata),
        .h_rdata  (h_rdata),
        .d_addr   (d_addr),
        .d_we     (d_we),
        .d_wdata  (d_wdata),
        .d_rdata  (d_rdata),
        .host_irq (host_irq),
        .dsp_irq  (dsp_irq)
    );

    // Vector: {dsp_writes, waddr, wdata, raddr, expected, req}
    localparam int NV = 16;
    localparam logic [84:0] TBL [NV] = '{
        {1'b0, 8'h00, 32'h0000_0001, 8'h00, 32'h0000_0001, 4'd2},  // R2 first set
        {1'b0, 8'h00, 32'h0000_0002, 8'h00, 32'h0000_0003, 4'd2},  // R2 OR, not overwrite
        {1'b1, 8'h04, 32'h0000_0001, 8'h00, 32'h0000_0002, 4'd3},  // R3 partial clear
        {1'b0, 8'h04, 32'h0000_0002, 8'h00, 32'h0000_0000, 4'd3},  // R3 final clear
        {1'b1, 8'h1C, 32'h8000_0002, 8'h1C, 32'h8000_0002, 4'd2},  // R2 outbound
        {1'b0, 8'h20, 32'h0000_0002, 8'h1C, 32'h8000_0000, 4'd3},  // R3 outbound partial
        {1'b0, 8'h20, 32'h8000_0000, 8'h1C, 32'h0000_0000, 4'd3},  // R3 outbound bit 31
        {1'b0, 8'h08, 32'hCAFE_0001, 8'h08, 32'hCAFE_0001, 4'd7},  // R7
        {1'b0, 8'h0C, 32'hCAFE_0002, 8'h0C, 32'hCAFE_0002, 4'd7},  // R7
        {1'b1, 8'h24, 32'hBEEF_0003, 8'h24, 32'hBEEF_0003, 4'd7},  // R7
        {1'b1, 8'h28, 32'hBEEF_0004, 8'h28, 32'hBEEF_0004, 4'd7},  // R7
        {1'b0, 8'h04, 32'hFFFF_FFFF, 8'h04, 32'h0000_0000, 4'd8},  // R8 clear reads zero
        {1'b0, 8'h40, 32'h0000_1234, 8'h40, 32'h0000_0000, 4'd8},  // R8 unmapped
        {1'b0, 8'h10, 32'h0000_0005, 8'h10, 32'h0000_0000, 4'd8},  // R8 hole in map
        {1'b1, 8'h20, 32'h0000_0005, 8'h20, 32'h0000_0000, 4'd8},  // R8 outbound clear
        {1'b0, 8'h14, 32'h1111_1111, 8'h08, 32'hCAFE_0001, 4'd8}   // R8 unmapped write leaves neighbours
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic dsp_wr(input logic [7:0] a, input logic [31:0] d);
        d_addr = a; d_wdata = d; d_we = 1'b1;
        @(negedge clk);
        d_we = 1'b0;
    endtask

    task automatic host_rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        h_addr = a;
        #1;
        check(req, h_rdata, exp);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; h_we = 1'b0; d_we = 1'b0;
        h_addr = '0; d_addr = '0; h_wdata = '0; d_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_rd_check("R1", 8'h00, 32'h0);
        host_rd_check("R1", 8'h1C, 32'h0);
        host_rd_check("R1", 8'h08, 32'h0);
        check("R1", {31'd0, host_irq}, 32'h0);
        check("R1", {31'd0, dsp_irq}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            v = TBL[i];
            if (v[84]) dsp_wr(v[83:76], v[75:44]);
            else       host_wr(v[83:76], v[75:44]);
            host_rd_check($sformatf("R%0d", v[3:0]), v[43:36], v[35:4]);
        end

        // R7 DSP-side read of an inbound message word
        d_addr = 8'h08; #1;
        check("R7", d_rdata, 32'hCAFE_0001);

        // R6 DSP interrupt timing
        host_wr(8'h00, 32'h1);
        check("R6", {31'd0, dsp_irq}, 32'h0);
        @(negedge clk);
        check("R6", {31'd0, dsp_irq}, 32'h1);
        dsp_wr(8'h04, 32'h1);
        check("R6", {31'd0, dsp_irq}, 32'h1);
        host_rd_check("R3", 8'h00, 32'h0);
        @(negedge clk);
        check("R6", {31'd0, dsp_irq}, 32'h0);

        // R5 host interrupt timing
        dsp_wr(8'h1C, 32'h2);
        check("R5", {31'd0, host_irq}, 32'h0);
        @(negedge clk);
        check("R5", {31'd0, host_irq}, 32'h1);
        host_wr(8'h20, 32'h2);
        check("R5", {31'd0, host_irq}, 32'h1);
        @(negedge clk);
        check("R5", {31'd0, host_irq}, 32'h0);

        // R4 set and clear in the same cycle, different bits
        h_addr = 8'h00; h_wdata = 32'h3; h_we = 1'b1;
        d_addr = 8'h04; d_wdata = 32'h1; d_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0; d_we = 1'b0;
        host_rd_check("R4", 8'h00, 32'h2);
        // R4 same bit: clear wins
        h_addr = 8'h00; h_wdata = 32'h4; h_we = 1'b1;
        d_addr = 8'h04; d_wdata = 32'h6; d_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0; d_we = 1'b0;
        host_rd_check("R4", 8'h00, 32'h0);
        // R4 outbound: DSP sets, host clears the same bit
        d_addr = 8'h1C; d_wdata = 32'h10; d_we = 1'b1;
        h_addr = 8'h20; h_wdata = 32'h10; h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0; d_we = 1'b0;
        host_rd_check("R4", 8'h1C, 32'h0);

        // R7 collision: host wins
        h_addr = 8'h24; h_wdata = 32'h1111_1111; h_we = 1'b1;
        d_addr = 8'h24; d_wdata = 32'h2222_2222; d_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0; d_we = 1'b0;
        host_rd_check("R7", 8'h24, 32'h1111_1111);

        // R9 full wipe
        host_wr(8'h00, 32'hFFFF_0000);
        dsp_wr(8'h1C, 32'h0000_FFFF);
        host_wr(8'h04, 32'hFFFF_FFFF);
        host_wr(8'h20, 32'hFFFF_FFFF);
        host_rd_check("R9", 8'h00, 32'h0);
        host_rd_check("R9", 8'h1C, 32'h0);
        @(negedge clk);
        check("R9", {30'd0, host_irq, dsp_irq}, 32'h0);

        finish_run();
    end

endmodule